// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block gathers eight interrupt request lines and presents one interrupt line to a processor. Priority is fixed: line 0 wins over every other line, and line 7 loses to every other line. The block holds three 8-bit state words: a pending word, an in-service word and a mask word. Each line can be set on its own to edge sensing or to level sensing. The processor answers a raised interrupt line with a one-cycle acknowledge pulse. The block then registers a vector, moves the winning line into the in-service word, and keeps a lower-priority request from interrupting work of higher priority.

Software sets the block up through a small write port, a select plus a byte. Select 0 writes the mask, select 1 writes the sensing mode and select 2 writes the vector base. Select 3 is a command port, and only one command is recognised: an end-of-service command that retires the most urgent service in progress. A request of higher priority can interrupt a service that is already running, so several in-service bits can be set at once. These nested services are retired in priority order.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the pending and in-service words are zero, all eight mask bits are set, every line senses edges, and the vector base is zero. irq_o is low and vector_o reads 0x00.
- R2: Every request line passes through two synchroniser flip-flops. In edge mode, a rising edge seen after synchronisation sets the pending bit. If an unmasked line rises with nothing in service, irq_o goes high on the third rising clock edge after the change.
- R3: In edge mode, an acknowledge that grants a line clears that line's pending bit. A new rising edge on the same line before its end-of-service command sets the bit again. irq_o then rises in the cycle after that command.
- R4: In level mode (mode bit = 1), the pending bit copies the synchronised pin in every cycle. An acknowledge does not clear it.
- R5: On an acknowledge, vector_o takes {base[7:3], index of the granted line}, from the next clock edge on. If no line is eligible, vector_o takes {base[7:3], 3'b111} and the in-service word does not change.
- R6: irq_o is high exactly when some pending, unmasked line has a lower index than every set in-service bit. Line 0 has the highest priority.
- R7: An acknowledge while irq_o is high sets the in-service bit of the eligible line with the lowest index. Bits already set stay set, so services nest.
- R8: Writing 0x20 on select 3 clears exactly one in-service bit, the set bit with the lowest index. Any other value written on select 3 changes nothing.
- R9: If a request is still pending when the end-of-service command clears the in-service bit that was blocking it, irq_o is high in the cycle after the write.
- R10: A set mask bit keeps its line from raising irq_o and from being granted, but the line's pending bit is still recorded. Clearing the mask bit then raises irq_o in the next cycle.
- R11: Select 0 writes the mask, select 1 writes the modes (bit i = 1 puts line i in level mode) and select 2 writes the vector base. Each write takes effect at the clock edge where wr_en is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Asynchronous request lines, bit 0 most urgent |
| ack | input | 1 | One-cycle acknowledge from the processor |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Write target: 0 mask, 1 mode, 2 base, 3 command |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Interrupt line to the processor |
| vector_o | output | 8 | Vector registered at the last acknowledge |

## Verification
The checker watches, in every cycle, how the in-service word changes:
- a granting acknowledge adds exactly one bit to it;
- an end-of-service command removes exactly one bit from it;
- it holds still in any cycle with neither an acknowledge nor a command;
- a spurious acknowledge leaves it untouched and returns index 7.

It also checks in every cycle that fully masked requests never raise irq_o. Other properties need a scenario to build up the state first:
- the exact latency through the synchronisers;
- the difference between edge and level lines at acknowledge;
- an edge that arrives again before the end-of-service command;
- nesting several levels deep.

The bench covers these with directed sequences and with a random run that it compares against its own cycle model.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int unsigned NIC_LINES = 8;
    localparam int unsigned NIC_IDX_W = $clog2(NIC_LINES);
    localparam int unsigned NIC_VEC_W = 8;
    localparam logic [7:0]  NIC_EOI_CMD = 8'h20;

    typedef logic [NIC_LINES-1:0] nic_bits_t;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_MODE = 2'd1,
        SEL_BASE = 2'd2,
        SEL_CMD  = 2'd3
    } nic_sel_e;

    typedef struct packed {
        nic_bits_t              pend;
        nic_bits_t              isr;
        nic_bits_t              mask;
        nic_bits_t              mode;
        logic [NIC_VEC_W-1:0]   base;
        logic [NIC_VEC_W-1:0]   vec;
    } nic_state_t;
endpackage

// File: rtl/nic_sync.sv
module nic_sync #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[i]};
        end
        assign sync_o[i] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_o;
    end

    assign rise_o = sync_o & ~prev_q;
endmodule

// File: rtl/nic_prio.sv
module nic_prio #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  onehot_o
);
    always_comb begin
        found_o  = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o  = 1'b1;
                idx_o    = IW'(i);
                onehot_o = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/nic_elig.sv
module nic_elig #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] isr_i,
    output logic [N-1:0] elig_o
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign blocked[i+1] = blocked[i] | isr_i[i];
        assign elig_o[i]    = req_i[i] & ~blocked[i+1];
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIC_LINES-1:0] irq_in,
    input  logic                 ack,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [7:0]           wr_data,
    output logic                 irq_o,
    output logic [NIC_VEC_W-1:0] vector_o
);
    localparam int unsigned SYNC_STAGES = 2;

    nic_state_t st_d, st_q;

    nic_bits_t sync_w, rise_w, req_w, elig_w;
    nic_bits_t grant_oh, retire_oh;
    logic [NIC_IDX_W-1:0] grant_idx, retire_idx;
    logic grant_found, retire_found;
    logic eoi_w;

    nic_bits_t isr_w, pend_w, mask_w;

    nic_sync #(.N(NIC_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (sync_w),
        .rise_o  (rise_w)
    );

    assign req_w = st_q.pend & ~st_q.mask;

    nic_elig #(.N(NIC_LINES)) u_elig (
        .req_i  (req_w),
        .isr_i  (st_q.isr),
        .elig_o (elig_w)
    );

    nic_prio #(.N(NIC_LINES)) u_grant (
        .vec_i    (elig_w),
        .found_o  (grant_found),
        .idx_o    (grant_idx),
        .onehot_o (grant_oh)
    );

    nic_prio #(.N(NIC_LINES)) u_retire (
        .vec_i    (st_q.isr),
        .found_o  (retire_found),
        .idx_o    (retire_idx),
        .onehot_o (retire_oh)
    );

    assign eoi_w = wr_en && (nic_sel_e'(wr_sel) == SEL_CMD) && (wr_data == NIC_EOI_CMD);

    always_comb begin
        nic_bits_t take_d;
        nic_bits_t drop_d;
        st_d   = st_q;
        take_d = '0;
        drop_d = '0;

        if (ack) begin
            if (grant_found) begin
                take_d = grant_oh;
                st_d.vec = {st_q.base[NIC_VEC_W-1:NIC_IDX_W], grant_idx};
            end else begin
                st_d.vec = {st_q.base[NIC_VEC_W-1:NIC_IDX_W], {NIC_IDX_W{1'b1}}};
            end
        end

        if (eoi_w && retire_found) drop_d = retire_oh;

        st_d.isr = (st_q.isr & ~drop_d) | take_d;

        for (int i = 0; i < NIC_LINES; i++) begin
            if (st_q.mode[i]) st_d.pend[i] = sync_w[i];
            else              st_d.pend[i] = (st_q.pend[i] & ~take_d[i]) | rise_w[i];
        end

        if (wr_en) begin
            case (nic_sel_e'(wr_sel))
                SEL_MASK: st_d.mask = wr_data[NIC_LINES-1:0];
                SEL_MODE: st_d.mode = wr_data[NIC_LINES-1:0];
                SEL_BASE: st_d.base = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.isr  <= '0;
            st_q.mask <= '1;
            st_q.mode <= '0;
            st_q.base <= '0;
            st_q.vec  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = |elig_w;
    assign vector_o = st_q.vec;

    assign isr_w  = st_q.isr;
    assign pend_w = st_q.pend;
    assign mask_w = st_q.mask;
endmodule

// File: rtl/nic_chk.sv
module nic_chk
    import nic_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ack,
    input logic                 eoi,
    input logic                 irq,
    input logic [NIC_LINES-1:0] isr,
    input logic [NIC_LINES-1:0] pend,
    input logic [NIC_LINES-1:0] mask,
    input logic [NIC_VEC_W-1:0] vec
);
    a_r7_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !eoi) |=> ($countones(isr) == $countones($past(isr)) + 1));

    a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr))));

    a_r8_isr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !eoi) |=> (isr == $past(isr)));

    a_r5_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq && !eoi) |=> ((vec[NIC_IDX_W-1:0] == {NIC_IDX_W{1'b1}}) && (isr == $past(isr))));

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) == '0) |-> !irq);
endmodule

bind nest_irq_ctrl nic_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .ack  (ack),
    .eoi  (eoi_w),
    .irq  (irq_o),
    .isr  (isr_w),
    .pend (pend_w),
    .mask (mask_w),
    .vec  (vector_o)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       irq_o;
    logic [7:0] vector_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit model_on = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .irq_o(irq_o), .vector_o(vector_o)
    );

    // Cycle model built from the requirements
    logic [7:0] m_s1, m_s2, m_prev, m_pend, m_isr, m_mask, m_mode, m_base, m_vec;

    function automatic logic [7:0] f_elig(input logic [7:0] p, i, m);
        logic [7:0] e = '0;
        bit blk = 0;
        for (int k = 0; k < 8; k++) begin
            blk = blk | i[k];
            e[k] = p[k] & ~m[k] & ~blk;
        end
        return e;
    endfunction

    function automatic int f_low(input logic [7:0] v);
        for (int k = 0; k < 8; k++) if (v[k]) return k;
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0; m_isr = 0;
            m_mask = 8'hFF; m_mode = 0; m_base = 0; m_vec = 0;
        end else begin
            logic [7:0] e, rise, n_pend, n_isr, take;
            int g, r;
            e = f_elig(m_pend, m_isr, m_mask);
            rise = m_s2 & ~m_prev;
            take = 0;
            n_isr = m_isr;
            if (ack) begin
                g = f_low(e);
                if (g >= 0) begin
                    take[g] = 1'b1;
                    m_vec = {m_base[7:3], 3'(g)};
                end else m_vec = {m_base[7:3], 3'b111};
            end
            if (wr_en && wr_sel == 2'd3 && wr_data == 8'h20) begin
                r = f_low(m_isr);
                if (r >= 0) n_isr[r] = 1'b0;
            end
            n_isr = n_isr | take;
            for (int k = 0; k < 8; k++)
                n_pend[k] = m_mode[k] ? m_s2[k] : ((m_pend[k] & ~take[k]) | rise[k]);
            if (wr_en) begin
                if (wr_sel == 2'd0) m_mask = wr_data;
                if (wr_sel == 2'd1) m_mode = wr_data;
                if (wr_sel == 2'd2) m_base = wr_data;
            end
            m_pend = n_pend;
            m_isr = n_isr;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = irq_in;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_ack();
        ack = 1;
        @(negedge clk);
        ack = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        irq_in = 0; ack = 0; wr_en = 0;
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(1);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240601));
        @(negedge clk);
        do_reset();
        chk("R1 irq after reset", irq_o, 0);
        chk("R1 vector after reset", vector_o, 8'h00);

        irq_in[3] = 1; wait_cyc(5);
        chk("R10 masked line quiet", irq_o, 0);
        wr(2'd0, 8'h00);
        chk("R10 pending kept under mask", irq_o, 1);
        wr(2'd2, 8'h40);
        do_ack();
        chk("R5 vector line3", vector_o, 8'h43);
        chk("R3 edge pending cleared", irq_o, 0);

        irq_in[5] = 1; wait_cyc(5);
        chk("R6 lower than in-service", irq_o, 0);
        irq_in[1] = 1; wait_cyc(2);
        chk("R2 two edges still low", irq_o, 0);
        wait_cyc(1);
        chk("R2 third edge high", irq_o, 1);
        do_ack();
        chk("R7 nested vector", vector_o, 8'h41);
        chk("R7 irq drops after nest", irq_o, 0);
        wr(2'd3, 8'h20);
        chk("R8 one bit cleared", irq_o, 0);
        wr(2'd3, 8'h21);
        chk("R8 other command ignored", irq_o, 0);
        wr(2'd3, 8'h20);
        chk("R9 reassert after eoi", irq_o, 1);
        do_ack();
        chk("R6 line5 vector", vector_o, 8'h45);
        wr(2'd3, 8'h20);
        chk("R8 all retired", irq_o, 0);
        do_ack();
        chk("R5 spurious vector", vector_o, 8'h47);

        irq_in[4] = 1; wait_cyc(4);
        chk("R3 line4 raised", irq_o, 1);
        do_ack();
        chk("R3 line4 vector", vector_o, 8'h44);
        irq_in[4] = 0; wait_cyc(3);
        irq_in[4] = 1; wait_cyc(4);
        chk("R3 self blocked", irq_o, 0);
        wr(2'd3, 8'h20);
        chk("R3 edge re-set before eoi", irq_o, 1);
        do_ack(); wr(2'd3, 8'h20);

        wr(2'd1, 8'h04);
        irq_in[2] = 1; wait_cyc(4);
        chk("R11 level line raised", irq_o, 1);
        do_ack();
        chk("R4 level vector", vector_o, 8'h42);
        wr(2'd3, 8'h20);
        chk("R4 ack leaves level pending", irq_o, 1);
        irq_in[2] = 0; wait_cyc(4);
        chk("R4 pending follows pin", irq_o, 0);

        wr(2'd0, 8'h04);
        irq_in[2] = 1; wait_cyc(4);
        chk("R10 masked level quiet", irq_o, 0);
        wr(2'd0, 8'h00);
        chk("R10 unmask raises", irq_o, 1);
        wr(2'd2, 8'h88);
        do_ack();
        chk("R11 new base", vector_o, 8'h8A);

        do_reset();
        for (int n = 0; n < 4000; n++) begin
            chk("R6 irq vs model", {7'd0, irq_o}, {7'd0, |f_elig(m_pend, m_isr, m_mask)});
            chk("R5 vector vs model", vector_o, m_vec);
            if ($urandom % 6 == 0) irq_in = irq_in ^ (8'd1 << ($urandom % 8));
            ack = ($urandom % 7 == 0);
            wr_en = ($urandom % 5 == 0);
            wr_sel = 2'($urandom % 4);
            wr_data = ($urandom % 3 == 0) ? 8'($urandom) : 8'h20;
            if (wr_sel == 2'd0) wr_data = 8'($urandom) & 8'($urandom);
            @(negedge clk);
        end
        ack = 0; wr_en = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule